// File: doc/BRIEF.md
# Serial Control Word Shifter

This block transfers one 32-bit configuration word to an external radio device over a three-line serial link. The lines are a data line, a shift clock and a latch strobe, all driven from the system clock. Every edge on the link is spaced by a half-bit delay of `HALF_DLY` system clocks. A start strobe captures the word together with a mode flag. The block then shifts the word out, starting with the most significant bit. At the end it either strobes the latch line at once or leaves the latch for later.

In deferred mode the block shifts the word but does not pulse the latch line. Instead it raises a pending flag, so the surrounding logic can choose the moment at which the device takes the new word. A separate latch request fires that pulse when the flag is set. While a sequence runs, `busy_o` is high. A one-cycle `done_o` marks the end of each shift sequence.

Top module: `ctlw_shifter`

## Requirements
- R1: The 32 bits of `word_i` leave on `sdata_o` starting with bit 31 and ending with bit 0. Each bit is the value of `sdata_o` at a rising edge of `sclk_o`, and each sequence has exactly 32 rising edges.
- R2: Within a sequence, `sclk_o` stays low for `HALF_DLY` cycles with the bit already on `sdata_o`, then high for `HALF_DLY` cycles. `sdata_o` does not change while `sclk_o` is high.
- R3: In immediate mode (`defer_i`=0), the last falling edge of `sclk_o` is followed at once by a high pulse on `sle_o` of `HALF_DLY` cycles, with `sdata_o` low. Afterwards `pend_o` is 0.
- R4: In deferred mode (`defer_i`=1), no `sle_o` pulse is produced. `pend_o` becomes 1 and `sdata_o` returns low.
- R5: When the block is idle and `pend_o`=1, `latch_now_i` produces one `sle_o` pulse of `HALF_DLY` cycles and then clears `pend_o`. When `pend_o`=0, `latch_now_i` has no effect.
- R6: `start_i` has no effect while `busy_o` is high.
- R7: `done_o` is high for exactly one cycle at the end of each shift sequence. A pulse requested with `latch_now_i` does not raise `done_o`.
- R8: While `rst_n` is low, and right after it, all outputs are 0 and the block is idle, even when reset interrupts a sequence.
- R9: When the block is idle, `sclk_o` and `sle_o` are low. `sclk_o` and `sle_o` are never high at the same time.
- R10: If `start_i` and `latch_now_i` arrive together while the block is idle, the start wins and the latch request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a shift sequence |
| word_i | input | 32 | Word to send, captured at start |
| defer_i | input | 1 | 1 = deferred latch, 0 = immediate latch |
| latch_now_i | input | 1 | Fire a pending latch pulse |
| sdata_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Serial shift clock |
| sle_o | output | 1 | Latch strobe |
| busy_o | output | 1 | Sequence or latch pulse in progress |
| done_o | output | 1 | One-cycle end-of-shift pulse |
| pend_o | output | 1 | Deferred latch outstanding |

## Verification
The checker assumes that `start_i` and `latch_now_i` are synchronous one-cycle requests. It also assumes that `word_i` and `defer_i` are valid in the cycle `start_i` is high, and that nothing on the inputs needs to hold after that cycle. The stimulus drives every request for exactly one cycle, away from the clock edge. It issues start requests during a sequence, and latch requests both with and without a pending latch, so that the requests meant to be ignored actually reach the block. Reset is asserted only as a whole-cycle event, including once in the middle of a sequence.

// File: rtl/ctlw_pkg.sv
package ctlw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_HIGH  = 2'd2,
      ST_LATCH = 2'd3
   } ctlw_state_e;
endpackage

// File: rtl/ctlw_tick.sv
// Phase timer: expire_o goes high in the last cycle of each HALF_DLY window while run_i is high.
module ctlw_tick #(
   parameter int HALF_DLY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expire_o
);
   localparam int CW = (HALF_DLY > 1) ? $clog2(HALF_DLY) : 1;

   generate
      if (HALF_DLY < 1) begin : g_bad_dly
         $error("ctlw_tick: HALF_DLY must be at least 1");
      end
      if (HALF_DLY == 1) begin : g_single
         assign expire_o = run_i;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (!run_i)        cnt_q <= '0;
            else if (expire_o)      cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end
         assign expire_o = run_i && (cnt_q == CW'(HALF_DLY - 1));
      end
   endgenerate
endmodule

// File: rtl/ctlw_shreg.sv
// Left-shifting word register with a count of the bits already sent.
module ctlw_shreg #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              msb_o,
   output logic              last_o
);
   localparam int BW = $clog2(WORD_W);

   generate
      if (WORD_W < 2) begin : g_bad_w
         $error("ctlw_shreg: WORD_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] sr_q;
   logic [BW-1:0]     sent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         sent_q <= '0;
      end else if (load_i) begin
         sr_q   <= word_i;
         sent_q <= '0;
      end else if (shift_i) begin
         sr_q   <= {sr_q[WORD_W-2:0], 1'b0};
         sent_q <= sent_q + 1'b1;
      end
   end

   assign msb_o  = sr_q[WORD_W-1];
   assign last_o = (sent_q == BW'(WORD_W - 1));
endmodule

// File: rtl/ctlw_shifter.sv
module ctlw_shifter
   import ctlw_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int HALF_DLY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              defer_i,
   input  logic              latch_now_i,
   output logic              sdata_o,
   output logic              sclk_o,
   output logic              sle_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              pend_o
);
   ctlw_state_e state_q;
   logic        defer_q, from_req_q, drive_q, sclk_q, sle_q, done_q, pend_q;
   logic        expire, msb, last, load, shift;

   assign load  = (state_q == ST_IDLE) && start_i;
   assign shift = (state_q == ST_HIGH) && expire && !last;

   ctlw_tick #(.HALF_DLY(HALF_DLY)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (state_q != ST_IDLE),
      .expire_o (expire)
   );

   ctlw_shreg #(.WORD_W(WORD_W)) u_shreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .shift_i (shift),
      .word_i  (word_i),
      .msb_o   (msb),
      .last_o  (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         defer_q    <= 1'b0;
         from_req_q <= 1'b0;
         drive_q    <= 1'b0;
         sclk_q     <= 1'b0;
         sle_q      <= 1'b0;
         done_q     <= 1'b0;
         pend_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  defer_q <= defer_i;
                  drive_q <= 1'b1;
                  state_q <= ST_SETUP;
               end else if (latch_now_i && pend_q) begin
                  sle_q      <= 1'b1;
                  from_req_q <= 1'b1;
                  state_q    <= ST_LATCH;
               end
            end
            ST_SETUP: begin
               if (expire) begin
                  sclk_q  <= 1'b1;
                  state_q <= ST_HIGH;
               end
            end
            ST_HIGH: begin
               if (expire) begin
                  sclk_q <= 1'b0;
                  if (!last) begin
                     state_q <= ST_SETUP;
                  end else if (defer_q) begin
                     drive_q <= 1'b0;
                     pend_q  <= 1'b1;
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     drive_q    <= 1'b0;
                     sle_q      <= 1'b1;
                     from_req_q <= 1'b0;
                     state_q    <= ST_LATCH;
                  end
               end
            end
            ST_LATCH: begin
               if (expire) begin
                  sle_q   <= 1'b0;
                  pend_q  <= 1'b0;
                  done_q  <= !from_req_q;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sdata_o = drive_q & msb;
   assign sclk_o  = sclk_q;
   assign sle_o   = sle_q;
   assign busy_o  = (state_q != ST_IDLE);
   assign done_o  = done_q;
   assign pend_o  = pend_q;
endmodule

// File: rtl/ctlw_shifter_chk.sv
module ctlw_shifter_chk (
   input logic clk,
   input logic rst_n,
   input logic latch_now_i,
   input logic sdata_o,
   input logic sclk_o,
   input logic sle_o,
   input logic busy_o,
   input logic done_o,
   input logic pend_o
);
   assert_data_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

   assert_latch_data_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sle_o |-> !sdata_o);

   assert_pend_rise_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_o) |-> (done_o && !sle_o));

   assert_latch_clears_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sle_o) |-> !pend_o);

   assert_no_latch_without_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !pend_o && latch_now_i) |=> !sle_o);

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!sclk_o && !sle_o));

   assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(sclk_o && sle_o));
endmodule

bind ctlw_shifter ctlw_shifter_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .latch_now_i (latch_now_i),
   .sdata_o     (sdata_o),
   .sclk_o      (sclk_o),
   .sle_o       (sle_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .pend_o      (pend_o)
);

// File: tb/ctlw_shifter_test.sv
module ctlw_shifter_test;
   localparam int D = 3;
   localparam int NV = 6;
   // {defer, word}
   localparam logic [32:0] VEC [NV] = '{
      {1'b0, 32'hA5C3_0F81},
      {1'b1, 32'h0000_0001},
      {1'b0, 32'h8000_0000},
      {1'b1, 32'hFFFF_FFFF},
      {1'b0, 32'h0000_0000},
      {1'b0, 32'h1234_5678}
   };

   logic clk = 0, rst_n = 0, start = 0, defer = 0, latch_now = 0;
   logic [31:0] word = '0;
   logic sdata, sclk, sle, busy, done, pend;
   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   ctlw_shifter #(.WORD_W(32), .HALF_DLY(D)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .word_i(word), .defer_i(defer),
      .latch_now_i(latch_now), .sdata_o(sdata), .sclk_o(sclk), .sle_o(sle),
      .busy_o(busy), .done_o(done), .pend_o(pend)
   );

   // port monitor, sampled at falling edges
   logic mon_clr = 0;
   logic [31:0] cap;
   int nrise, hi_run, lo_run, hi_min, hi_max, lo_min, lo_max;
   int le_cnt, le_at, le_run, le_w, le_dbad, done_cnt;
   logic p_sclk, p_sle;

   always @(negedge clk) begin
      if (mon_clr) begin
         cap = '0; nrise = 0; hi_run = 0; lo_run = 0;
         hi_min = 9999; hi_max = 0; lo_min = 9999; lo_max = 0;
         le_cnt = 0; le_at = -1; le_run = 0; le_w = 0; le_dbad = 0; done_cnt = 0;
      end else begin
         if (sclk && !p_sclk) begin
            cap = {cap[30:0], sdata};
            nrise++;
            if (lo_run < lo_min) lo_min = lo_run;
            if (lo_run > lo_max) lo_max = lo_run;
            lo_run = 0;
            hi_run = 1;
         end else if (sclk) hi_run++;
         if (!sclk && p_sclk) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
         end
         if (busy && !sclk && !sle) lo_run++;
         if (sle && !p_sle) begin le_cnt++; le_at = nrise; le_run = 1; end
         else if (sle) le_run++;
         if (sle && sdata) le_dbad++;
         if (!sle && p_sle) le_w = le_run;
         if (done) done_cnt++;
      end
      p_sclk = sclk;
      p_sle = sle;
   end

   task automatic chk(input logic ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clr_mon();
      @(negedge clk); mon_clr = 1;
      @(negedge clk); mon_clr = 0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 2000) begin @(negedge clk); n++; end
      @(negedge clk);
   endtask

   task automatic launch(input logic [31:0] w, input logic d, input logic ln);
      word = w; defer = d; start = 1; latch_now = ln;
      @(negedge clk);
      start = 0; latch_now = 0; word = '0; defer = 0;
   endtask

   task automatic check_seq(input logic [31:0] w, input logic d, input string tag);
      chk(cap == w, {"R1 word ", tag}, cap, w);
      chk(nrise == 32, {"R1 edges ", tag}, nrise, 32);
      chk(hi_min == D && hi_max == D, {"R2 high width ", tag}, hi_max, D);
      chk(lo_min == D && lo_max == D, {"R2 low width ", tag}, lo_max, D);
      chk(done_cnt == 1, {"R7 done ", tag}, done_cnt, 1);
      chk(sdata == 0, {"R3 R4 data low ", tag}, sdata, 0);
      if (d) begin
         chk(le_cnt == 0, {"R4 no latch ", tag}, le_cnt, 0);
         chk(pend == 1, {"R4 pend ", tag}, pend, 1);
      end else begin
         chk(le_cnt == 1 && le_at == 32, {"R3 latch after last bit ", tag}, le_at, 32);
         chk(le_w == D, {"R3 latch width ", tag}, le_w, D);
         chk(le_dbad == 0, {"R3 data low in latch ", tag}, le_dbad, 0);
         chk(pend == 0, {"R3 pend clear ", tag}, pend, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      clr_mon();
      // R8: reset state
      @(negedge clk);
      chk({sdata, sclk, sle, busy, done, pend} == 6'b0, "R8 in reset", {sdata, sclk, sle, busy, done, pend}, 0);
      rst_n = 1;
      @(negedge clk);
      chk({sdata, sclk, sle, busy, done, pend} == 6'b0, "R8 after reset", {sdata, sclk, sle, busy, done, pend}, 0);

      // table walk: R1..R4, R7
      for (int i = 0; i < NV; i++) begin
         clr_mon();
         launch(VEC[i][31:0], VEC[i][32], 1'b0);
         wait_idle();
         @(negedge clk);
         check_seq(VEC[i][31:0], VEC[i][32], $sformatf("vec%0d", i));
         chk(!sclk && !sle, "R9 idle lines low", {sclk, sle}, 0);
      end

      // R5: pending latch fired by request (pend is 0 here: last vector immediate)
      clr_mon();
      launch(32'hC0DE_0042, 1'b1, 1'b0);
      wait_idle();
      check_seq(32'hC0DE_0042, 1'b1, "defer before req");
      clr_mon();
      latch_now = 1; @(negedge clk); latch_now = 0;
      wait_idle();
      chk(le_cnt == 1 && le_w == D, "R5 requested latch width", le_w, D);
      chk(pend == 0, "R5 pend cleared", pend, 0);
      chk(done_cnt == 0, "R7 no done on request", done_cnt, 0);
      // R5: request without pending has no effect
      clr_mon();
      latch_now = 1; @(negedge clk); latch_now = 0;
      repeat (3 * D) @(negedge clk);
      chk(le_cnt == 0 && !busy, "R5 request ignored w/o pend", le_cnt, 0);

      // R6: start while busy ignored
      clr_mon();
      launch(32'h5A5A_F00F, 1'b0, 1'b0);
      repeat (10 * D) @(negedge clk);
      launch(32'h0F0F_1111, 1'b1, 1'b0);
      wait_idle();
      check_seq(32'h5A5A_F00F, 1'b0, "R6 busy start");
      repeat (4) @(negedge clk);
      chk(nrise == 32 && done_cnt == 1, "R6 second start dropped", nrise, 32);

      // R10: start and latch request together with pend set
      clr_mon();
      launch(32'h0000_FFFF, 1'b1, 1'b0);
      wait_idle();
      chk(pend == 1, "R10 setup pend", pend, 1);
      clr_mon();
      launch(32'h3C3C_9696, 1'b0, 1'b1);
      wait_idle();
      check_seq(32'h3C3C_9696, 1'b0, "R10 start wins");

      // R8: reset in mid-sequence
      clr_mon();
      launch(32'hFFFF_FFFF, 1'b1, 1'b0);
      repeat (20 * D) @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      chk({sdata, sclk, sle, busy, done, pend} == 6'b0, "R8 reset mid-sequence", {sdata, sclk, sle, busy, done, pend}, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      chk({sdata, sclk, sle, busy, pend} == 5'b0, "R8 stays idle", {sdata, sclk, sle, busy, pend}, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule